// File: doc/BRIEF.md
# Fractional-N Output Clock Divider

This block derives a slower clock from a fast input clock by a programmable ratio of 2 × (N + F/2^28), where N is an 18-bit integer part and F a 28-bit fraction. The output flips level once per half-period. Each half-period lasts either N or N+1 input cycles. A fractional accumulator picks between the two, so the average ratio is exact and not just approximate.

Software writes N and F together with a single load strobe. That strobe also acts as the synchronisation point. A valid load restarts the half-period count and the accumulator, and drives the output low, so that several dividers loaded in the same cycle stay phase-aligned. A setting the divider cannot realise is refused, and the divider carries on with its old setting as if nothing happened. The integer and fraction widths are parameters, with defaults of 18 and 28 bits.

Top module: `fracn_clkdiv`

## Requirements
- R1: Counting half-periods from a valid load with k = 0, 1, 2, ..., half-period k lasts N + floor((k+1)·F/2^FRAC_W) − floor(k·F/2^FRAC_W) input cycles. Each half-period is therefore N or N+1 cycles, and half-period 0 is always N cycles.
- R2: Over any 2^FRAC_W consecutive half-periods that start at a valid load, the total is exactly N·2^FRAC_W + F input cycles.
- R3: The output changes level exactly at the clock edge that closes a half-period, and at no other edge unless a valid load occurs.
- R4: A load with valid settings latches N and F and restarts the accumulator and the cycle count. The output is low after the edge that samples the strobe, and the first rising edge follows N cycles later.
- R5: N = 3 is accepted when F = 0, which gives half-periods of 3 cycles.
- R6: A load with N < 3, or with N = 3 and F ≠ 0, is ignored. The output level, the half-period phase and the active N and F all continue as before.
- R7: After reset the output is low and the divider runs with N = 4 and F = 0, that is, divide by 8.
- R8: With F = 0, every half-period lasts exactly N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load/sync strobe, sampled on the rising edge of clk |
| n_in | input | INT_W (18) | Integer part N of the ratio |
| f_in | input | FRAC_W (28) | Fraction F, scaled by 2^-FRAC_W |
| clk_out | output | 1 | Divided clock |

## Verification
A corrupted accumulator or a wrong carry only becomes visible at the ports when some half-period runs one cycle too long or too short. The bench therefore measures every half-period length against the floor formula. Over a full accumulator wrap it also checks the total cycle count, which catches a lost or extra carry that one local look could miss. A mishandled load shows up within a single half-period, either as the wrong level just after the strobe or as the next edge arriving at the wrong cycle. The bench uses a reduced fraction width so that a full wrap stays short.

// File: rtl/fracn_clkdiv.sv
module fracn_clkdiv #(
  parameter int INT_W  = 18,
  parameter int FRAC_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  n_in,
  input  logic [FRAC_W-1:0] f_in,
  output logic              clk_out
);
  localparam int CW = INT_W + 1;
  localparam logic [INT_W-1:0] N_RST = INT_W'(4);

  logic [INT_W-1:0]  n_r;
  logic [FRAC_W-1:0] f_r, acc, sum;
  logic [CW-1:0]     len_r, cnt;
  logic              carry;

  wire accept   = load && ((n_in > INT_W'(3)) || (n_in == INT_W'(3) && f_in == '0));
  wire half_end = (cnt == len_r - CW'(1));

  assign {carry, sum} = {1'b0, acc} + {1'b0, f_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_r     <= N_RST;
      f_r     <= '0;
      acc     <= '0;
      len_r   <= CW'(N_RST);
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (accept) begin
      n_r     <= n_in;
      f_r     <= f_in;
      acc     <= f_in;
      len_r   <= {1'b0, n_in};
      cnt     <= '0;
      clk_out <= 1'b0;
    end else if (half_end) begin
      cnt     <= '0;
      clk_out <= ~clk_out;
      acc     <= sum;
      len_r   <= {1'b0, n_r} + CW'(carry);
    end else begin
      cnt     <= cnt + CW'(1);
    end
  end
endmodule

module fracn_clkdiv_chk #(
  parameter int INT_W  = 18,
  parameter int FRAC_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic [INT_W-1:0]  n_in,
  input logic [FRAC_W-1:0] f_in,
  input logic              clk_out,
  input logic [INT_W-1:0]  n_r,
  input logic [FRAC_W-1:0] f_r,
  input logic [INT_W:0]    len_r,
  input logic [INT_W:0]    cnt
);
  logic ok_set;
  assign ok_set = (n_in >= INT_W'(4)) || (n_in == INT_W'(3) && f_in == '0);

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len_r >= {1'b0, n_r}) && (len_r <= {1'b0, n_r} + 1'b1)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len_r); // R3
  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && ok_set) |=> (!clk_out && cnt == '0)); // R4
  AST_N_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (n_r > INT_W'(3)) || (n_r == INT_W'(3) && f_r == '0)); // R5
  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ok_set) |=> (n_r == $past(n_r) && f_r == $past(f_r))); // R6
  AST_INT_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (f_r == '0) |-> (len_r == {1'b0, n_r})); // R8
endmodule

bind fracn_clkdiv fracn_clkdiv_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .n_in(n_in), .f_in(f_in),
  .clk_out(clk_out), .n_r(n_r), .f_r(f_r), .len_r(len_r), .cnt(cnt)
);

// File: tb/fracn_clkdiv_test.sv
module fracn_clkdiv_test;
  localparam int PERIOD = 10;
  localparam int IW = 18;
  localparam int FW = 8;

  logic clk = 0, rst_n = 0, load = 0;
  logic [IW-1:0] n_in = '0;
  logic [FW-1:0] f_in = '0;
  logic clk_out;
  int checks = 0, errors = 0;

  fracn_clkdiv #(.INT_W(IW), .FRAC_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .load(load), .n_in(n_in), .f_in(f_in), .clk_out(clk_out)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint exp_len(input longint n, input longint f, input longint k);
    return n + (((k + 1) * f) >> FW) - ((k * f) >> FW);
  endfunction

  task automatic wait_toggle(output int c);
    logic prev = clk_out;
    c = 0;
    do begin
      @(negedge clk);
      c++;
    end while (clk_out == prev && c < 3000);
  endtask

  task automatic do_load(input int n, input int f);
    n_in = IW'(n); f_in = FW'(f); load = 1;
    @(negedge clk);
    load = 0;
  endtask

  task automatic t_reset;
    int c;
    check(clk_out == 1'b0, "R7 reset level", clk_out, 0);
    for (int k = 0; k < 4; k++) begin
      wait_toggle(c);
      check(c == 4, "R7 reset half-period", c, 4);
    end
  endtask

  task automatic t_integer(input int n);
    int c;
    do_load(n, 0);
    check(clk_out == 1'b0, "R4 low after load", clk_out, 0);
    for (int k = 0; k < 5; k++) begin
      wait_toggle(c);
      check(c == n, "R8 integer half-period", c, n);
    end
  endtask

  task automatic t_n3;
    int c;
    do_load(3, 0);
    for (int k = 0; k < 4; k++) begin
      wait_toggle(c);
      check(c == 3, "R5 N=3 half-period", c, 3);
    end
  endtask

  task automatic t_frac(input int n, input int f, input int halves, input bit total);
    int c;
    longint sum = 0;
    do_load(n, f);
    for (int k = 0; k < halves; k++) begin
      wait_toggle(c);
      sum += c;
      check(c == exp_len(n, f, k), "R1 fractional half-period", c, exp_len(n, f, k));
    end
    if (total)
      check(sum == longint'(n) * (1 << FW) + f, "R2 total over wrap", sum, longint'(n) * (1 << FW) + f);
  endtask

  task automatic t_reject(input int bn, input int bf);
    int c;
    logic lvl;
    do_load(6, 0);
    wait_toggle(c);
    check(c == 6, "R4 first half after load", c, 6);
    lvl = clk_out;
    n_in = IW'(bn); f_in = FW'(bf); load = 1;
    @(negedge clk);
    load = 0;
    @(negedge clk);
    check(clk_out == lvl, "R6 level kept", clk_out, lvl);
    wait_toggle(c);
    check(c == 4, "R6 phase kept", c, 4);
    wait_toggle(c);
    check(c == 6, "R6 old N kept", c, 6);
  endtask

  task automatic t_resync;
    int c;
    do_load(7, 0);
    wait_toggle(c);
    repeat (3) @(negedge clk);
    check(clk_out == 1'b1, "R3 level mid half-period", clk_out, 1);
    do_load(5, 0);
    check(clk_out == 1'b0, "R4 load forces low", clk_out, 0);
    wait_toggle(c);
    check(c == 5, "R4 restart count", c, 5);
    check(clk_out == 1'b1, "R4 first edge rises", clk_out, 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_integer(5);
    t_integer(9);
    t_n3();
    t_frac(4, 128, 8, 0);
    t_frac(5, 77, 256, 1);
    t_frac(3 + 1, 255, 256, 1);
    t_frac(10, 1, 256, 1);
    t_reject(3, 1);
    t_reject(2, 0);
    t_reject(0, 5);
    t_resync();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule